// File: doc/BRIEF.md
# CAN Message Slot Filter and Arbiter

This block holds the configuration of a bank of message slots for a CAN controller and decides, frame by frame, which slot is involved. Each slot is inactive, armed for transmit or armed for receive, and carries an identifier, IDE and RTR values, a don't-care mask for each of them, an auto-reply bit and a done flag. On the transmit side the block presents the one armed slot that should go on the bus next. On the receive side it compares each incoming header against every receive slot and names the slot that takes the frame. Bit-level framing and payload storage live in neighbouring blocks.

The top slots can be merged into a small receive queue that stores headers, filters with the lowest of those slots and reports on it. Remote frames drive two automatic behaviours: a transmit slot marked for auto-reply waits for a matching remote request before it sends, and a receive slot marked for auto-reply waits until a matching remote frame has gone out before it accepts the answer.

Top module: `msgslot_hub`

## Requirements
- R1: After reset every slot is inactive, `done` is all zero, `irq` is 0, `tx_req_valid` is 0, `fifo_empty` is 1 and `fifo_ovf` is 0.
- R2: A configuration write with `cfg_mode` 1 arms a transmit slot; `tx_req_valid` is 1 whenever a transmit slot is eligible, and `tx_req_slot` with `tx_req_id`, `tx_req_ide`, `tx_req_rtr` then show the eligible slot with the lowest index.
- R3: A `tx_done` pulse while `tx_req_valid` is 1 makes the requested slot inactive and sets its `done` bit on the next clock.
- R4: In a receive slot (`cfg_mode` 2) each mask bit of 1 makes the matching identifier, IDE or RTR bit a don't-care and each mask bit of 0 demands an exact match.
- R5: Among receive slots that accept a frame, the highest index takes it: one clock after `rx_valid`, `rx_hit_valid` is 1 with `rx_hit_slot`, that slot's `done` bit is set and the slot becomes inactive.
- R6: A frame that no receive slot accepts leaves `rx_hit_valid` at 0 and `done` unchanged.
- R7: `done` bits stay set until a 1 on the same bit of `done_clr`; `irq` is the OR of `done & irq_en`.
- R8: With `fifo_mode` at 1 the top four slots form a 4-entry header queue filtered by slot NUM_SLOTS-4's settings; it outranks every other receive slot, reports hits and `done` on slot NUM_SLOTS-4, stays armed, and returns headers in arrival order on `fifo_head_*`, advanced by `fifo_pop`.
- R9: A frame matching the full queue is dropped (no hit, no other slot takes it) and sets `fifo_ovf`, which holds until `fifo_ovf_clr`.
- R10: A transmit slot with `cfg_auto` 1 is not eligible until a remote frame (`rx_rtr` 1) with its exact identifier and IDE is received; after that it requests with its own header.
- R11: A receive slot with `cfg_auto` 1 accepts nothing until a transmitted remote frame whose identifier and IDE pass its filter completes via `tx_done`.
- R12: A slot that finished takes no part until it is written again; a fresh write re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one slot's configuration |
| cfg_slot | input | SLOT_W | Slot written |
| cfg_mode | input | 2 | 0 inactive, 1 transmit, 2 receive |
| cfg_id | input | ID_W | Identifier |
| cfg_id_mask | input | ID_W | Identifier don't-care mask |
| cfg_ide | input | 1 | IDE value |
| cfg_ide_mask | input | 1 | IDE don't-care |
| cfg_rtr | input | 1 | RTR value |
| cfg_rtr_mask | input | 1 | RTR don't-care |
| cfg_auto | input | 1 | Auto-reply bit |
| fifo_mode | input | 1 | Merge top slots into the header queue |
| rx_valid | input | 1 | Received header strobe |
| rx_id | input | ID_W | Received identifier |
| rx_ide | input | 1 | Received IDE |
| rx_rtr | input | 1 | Received RTR |
| rx_hit_valid | output | 1 | Last header was accepted |
| rx_hit_slot | output | SLOT_W | Accepting slot |
| tx_req_valid | output | 1 | A slot is ready to send |
| tx_req_slot | output | SLOT_W | Slot to send |
| tx_req_id | output | ID_W | Its identifier |
| tx_req_ide | output | 1 | Its IDE |
| tx_req_rtr | output | 1 | Its RTR |
| tx_done | input | 1 | Requested slot was sent |
| done | output | NUM_SLOTS | Per-slot done flags |
| done_clr | input | NUM_SLOTS | Write-one-to-clear for done |
| irq_en | input | NUM_SLOTS | Per-slot interrupt enable |
| irq | output | 1 | Interrupt |
| fifo_pop | input | 1 | Drop the queue head |
| fifo_empty | output | 1 | Queue empty |
| fifo_head_id | output | ID_W | Head identifier |
| fifo_head_ide | output | 1 | Head IDE |
| fifo_head_rtr | output | 1 | Head RTR |
| fifo_ovf | output | 1 | Sticky queue overflow |
| fifo_ovf_clr | input | 1 | Clears fifo_ovf |

## Verification
Receive results (`rx_hit_valid`, `rx_hit_slot`, `done`, queue state, `fifo_ovf`) are registered and are due one clock after the `rx_valid` cycle; `done` after `tx_done` is also due one clock later, while the transmit request is combinational from slot state and so changes in the clock after the write, trigger or completion that altered it. The bench drives every stimulus for exactly one cycle from a falling edge and samples at the following falling edge, after the single capturing rising edge. Sweeps cover transmit order over several armed-slot patterns, receive order with all sixteen slots accepting, and every identifier bit of the mask individually.

// File: rtl/msgslot_pkg.sv
package msgslot_pkg;

   typedef enum logic [1:0] {
      SLOT_OFF = 2'd0,
      SLOT_TX  = 2'd1,
      SLOT_RX  = 2'd2
   } slot_mode_e;

   // Per-slot control bits; pend means "triggered" for an auto TX slot
   // and "primed" for an auto RX slot.
   typedef struct packed {
      slot_mode_e mode;
      logic       ide;
      logic       ide_m;
      logic       rtr;
      logic       rtr_m;
      logic       auto_rep;
      logic       pend;
   } slot_flags_t;

endpackage

// File: rtl/slot_filter.sv
module slot_filter #(
   parameter int ID_W = 29
) (
   input  logic [ID_W-1:0] f_id,
   input  logic [ID_W-1:0] f_idm,
   input  logic            f_ide,
   input  logic            f_idem,
   input  logic            f_rtr,
   input  logic            f_rtrm,
   input  logic [ID_W-1:0] h_id,
   input  logic            h_ide,
   input  logic            h_rtr,
   output logic            hit
);
   // a set mask bit removes that bit from the comparison
   assign hit = (((h_id ^ f_id) & ~f_idm) == '0)
             && (((h_ide ^ f_ide) & ~f_idem) == 1'b0)
             && (((h_rtr ^ f_rtr) & ~f_rtrm) == 1'b0);
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
   parameter int N          = 16,
   parameter bit HIGH_FIRST = 1'b0,
   parameter int IW         = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          valid,
   output logic [IW-1:0] idx
);
   assign valid = |req;

   generate
      if (HIGH_FIRST) begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (req[i]) idx = IW'(i);
         end
      end else begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (req[i]) idx = IW'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/hdr_fifo.sv
module hdr_fifo #(
   parameter int W     = 31,
   parameter int DEPTH = 4,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          pop_eff;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign pop_eff = pop && !empty;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push)    wp <= wp + 1'b1;
         if (pop_eff) rp <= rp + 1'b1;
         cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop_eff};
      end
   end

   AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);                                               // R9
   AST_FIFO_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      empty && !push |=> empty);                                     // R8
endmodule

// File: rtl/msgslot_hub.sv
module msgslot_hub
   import msgslot_pkg::*;
#(
   parameter int NUM_SLOTS  = 16,
   parameter int ID_W       = 29,
   parameter int FIFO_DEPTH = 4,
   parameter int SLOT_W     = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [SLOT_W-1:0]    cfg_slot,
   input  logic [1:0]           cfg_mode,
   input  logic [ID_W-1:0]      cfg_id,
   input  logic [ID_W-1:0]      cfg_id_mask,
   input  logic                 cfg_ide,
   input  logic                 cfg_ide_mask,
   input  logic                 cfg_rtr,
   input  logic                 cfg_rtr_mask,
   input  logic                 cfg_auto,
   input  logic                 fifo_mode,
   input  logic                 rx_valid,
   input  logic [ID_W-1:0]      rx_id,
   input  logic                 rx_ide,
   input  logic                 rx_rtr,
   output logic                 rx_hit_valid,
   output logic [SLOT_W-1:0]    rx_hit_slot,
   output logic                 tx_req_valid,
   output logic [SLOT_W-1:0]    tx_req_slot,
   output logic [ID_W-1:0]      tx_req_id,
   output logic                 tx_req_ide,
   output logic                 tx_req_rtr,
   input  logic                 tx_done,
   output logic [NUM_SLOTS-1:0] done,
   input  logic [NUM_SLOTS-1:0] done_clr,
   input  logic [NUM_SLOTS-1:0] irq_en,
   output logic                 irq,
   input  logic                 fifo_pop,
   output logic                 fifo_empty,
   output logic [ID_W-1:0]      fifo_head_id,
   output logic                 fifo_head_ide,
   output logic                 fifo_head_rtr,
   output logic                 fifo_ovf,
   input  logic                 fifo_ovf_clr
);
   localparam int FIFO_BASE = NUM_SLOTS - FIFO_DEPTH;
   localparam int HDR_W     = ID_W + 2;

   // elaboration-time parameter checks
   generate
      if (NUM_SLOTS < 2)
         begin : g_bad_slots $error("NUM_SLOTS must be at least 2"); end
      if (SLOT_W != $clog2(NUM_SLOTS))
         begin : g_bad_sw $error("SLOT_W must equal clog2(NUM_SLOTS)"); end
      if (FIFO_DEPTH < 2 || FIFO_DEPTH >= NUM_SLOTS || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)
         begin : g_bad_fifo $error("FIFO_DEPTH must be a power of two below NUM_SLOTS"); end
      if (ID_W < 11)
         begin : g_bad_id $error("ID_W must hold a standard identifier"); end
   endgenerate

   slot_flags_t           s_fl  [NUM_SLOTS];
   logic [ID_W-1:0]       s_id  [NUM_SLOTS];
   logic [ID_W-1:0]       s_idm [NUM_SLOTS];
   logic [NUM_SLOTS-1:0]  done_q, done_set;
   logic [NUM_SLOTS-1:0]  rxf_hit, prime_hit, rx_acc, rx_req, tx_cand, trig;
   logic                  rx_any, fifo_hit, fifo_full, fifo_push, fifo_drop, rx_take, tx_fire;
   logic [SLOT_W-1:0]     rx_sel;
   logic                  hit_q, ovf_q;
   logic [SLOT_W-1:0]     hit_slot_q;
   logic [HDR_W-1:0]      fifo_head;

   // per-slot filters: one against the received header, one against the
   // outgoing header to prime auto-reply receivers (RTR ignored there)
   generate
      for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
         slot_filter #(.ID_W(ID_W)) u_rxf (
            .f_id (s_id[k]), .f_idm (s_idm[k]),
            .f_ide(s_fl[k].ide), .f_idem(s_fl[k].ide_m),
            .f_rtr(s_fl[k].rtr), .f_rtrm(s_fl[k].rtr_m),
            .h_id (rx_id), .h_ide(rx_ide), .h_rtr(rx_rtr),
            .hit  (rxf_hit[k]));
         slot_filter #(.ID_W(ID_W)) u_prf (
            .f_id (s_id[k]), .f_idm (s_idm[k]),
            .f_ide(s_fl[k].ide), .f_idem(s_fl[k].ide_m),
            .f_rtr(s_fl[k].rtr), .f_rtrm(1'b1),
            .h_id (tx_req_id), .h_ide(tx_req_ide), .h_rtr(tx_req_rtr),
            .hit  (prime_hit[k]));
      end
   endgenerate

   always_comb begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
         rx_acc[k]  = (s_fl[k].mode == SLOT_RX) && (!s_fl[k].auto_rep || s_fl[k].pend)
                   && rxf_hit[k];
         rx_req[k]  = rx_acc[k] && !(fifo_mode && (k >= FIFO_BASE));
         tx_cand[k] = (s_fl[k].mode == SLOT_TX) && (!s_fl[k].auto_rep || s_fl[k].pend);
         trig[k]    = rx_valid && rx_rtr && (s_fl[k].mode == SLOT_TX) && s_fl[k].auto_rep
                   && !s_fl[k].pend && (s_id[k] == rx_id) && (s_fl[k].ide == rx_ide);
      end
   end

   slot_pick #(.N(NUM_SLOTS), .HIGH_FIRST(1'b0), .IW(SLOT_W)) u_tx_pick (
      .req(tx_cand), .valid(tx_req_valid), .idx(tx_req_slot));
   slot_pick #(.N(NUM_SLOTS), .HIGH_FIRST(1'b1), .IW(SLOT_W)) u_rx_pick (
      .req(rx_req), .valid(rx_any), .idx(rx_sel));

   assign tx_req_id  = s_id[tx_req_slot];
   assign tx_req_ide = s_fl[tx_req_slot].ide;
   assign tx_req_rtr = s_fl[tx_req_slot].rtr;

   assign fifo_hit  = fifo_mode && rx_acc[FIFO_BASE];
   assign fifo_push = rx_valid && fifo_hit && !fifo_full;
   assign fifo_drop = rx_valid && fifo_hit && fifo_full;
   assign rx_take   = rx_valid && !fifo_hit && rx_any;
   assign tx_fire   = tx_done && tx_req_valid;

   always_comb begin
      done_set = '0;
      if (tx_fire)   done_set[tx_req_slot] = 1'b1;
      if (fifo_push) done_set[FIFO_BASE]   = 1'b1;
      if (rx_take)   done_set[rx_sel]      = 1'b1;
   end

   hdr_fifo #(.W(HDR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop),
      .din({rx_ide, rx_rtr, rx_id}), .head(fifo_head),
      .empty(fifo_empty), .full(fifo_full));

   assign {fifo_head_ide, fifo_head_rtr, fifo_head_id} = fifo_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_SLOTS; k++) begin
            s_fl[k]  <= '0;
            s_id[k]  <= '0;
            s_idm[k] <= '0;
         end
         done_q     <= '0;
         hit_q      <= 1'b0;
         hit_slot_q <= '0;
         ovf_q      <= 1'b0;
      end else begin
         for (int k = 0; k < NUM_SLOTS; k++) begin
            if (trig[k]) s_fl[k].pend <= 1'b1;
            if (tx_fire && tx_req_rtr && prime_hit[k] && (s_fl[k].mode == SLOT_RX)
                && s_fl[k].auto_rep)
               s_fl[k].pend <= 1'b1;
            if ((tx_fire && tx_req_slot == SLOT_W'(k)) || (rx_take && rx_sel == SLOT_W'(k))) begin
               s_fl[k].mode <= SLOT_OFF;
               s_fl[k].pend <= 1'b0;
            end
            if (cfg_we && cfg_slot == SLOT_W'(k)) begin
               s_fl[k].mode     <= slot_mode_e'(cfg_mode);
               s_fl[k].ide      <= cfg_ide;
               s_fl[k].ide_m    <= cfg_ide_mask;
               s_fl[k].rtr      <= cfg_rtr;
               s_fl[k].rtr_m    <= cfg_rtr_mask;
               s_fl[k].auto_rep <= cfg_auto;
               s_fl[k].pend     <= 1'b0;
               s_id[k]          <= cfg_id;
               s_idm[k]         <= cfg_id_mask;
            end
         end
         done_q     <= (done_q & ~done_clr) | done_set;
         hit_q      <= rx_valid && (fifo_hit ? !fifo_full : rx_any);
         hit_slot_q <= fifo_hit ? SLOT_W'(FIFO_BASE) : rx_sel;
         if (fifo_ovf_clr) ovf_q <= 1'b0;
         if (fifo_drop)    ovf_q <= 1'b1;
      end
   end

   assign done         = done_q;
   assign irq          = |(done_q & irq_en);
   assign rx_hit_valid = hit_q;
   assign rx_hit_slot  = hit_slot_q;
   assign fifo_ovf     = ovf_q;

   AST_TX_PICK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req_valid |-> tx_cand[tx_req_slot]);                        // R2
   AST_TX_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fire |=> done[$past(tx_req_slot)]);                         // R3
   AST_TX_SLOT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fire && !cfg_we |=> !(tx_req_valid && tx_req_slot == $past(tx_req_slot))); // R12
   AST_RX_HIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hit_valid |-> done[rx_hit_slot]);                           // R5
   AST_NO_FRAME_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !rx_hit_valid);                                  // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ovf && !fifo_ovf_clr |=> fifo_ovf);                       // R9
   AST_FIFO_HIT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |=> rx_hit_valid && rx_hit_slot == SLOT_W'(FIFO_BASE)); // R8
endmodule

// File: tb/tb_msgslot_hub.sv
module tb_msgslot_hub;
   localparam int N  = 16;
   localparam int IW = 29;
   localparam int SW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          cfg_we, cfg_ide, cfg_ide_mask, cfg_rtr, cfg_rtr_mask, cfg_auto;
   logic [SW-1:0] cfg_slot;
   logic [1:0]    cfg_mode;
   logic [IW-1:0] cfg_id, cfg_id_mask;
   logic          fifo_mode, rx_valid, rx_ide, rx_rtr, tx_done, fifo_pop, fifo_ovf_clr;
   logic [IW-1:0] rx_id;
   logic [N-1:0]  done_clr, irq_en;
   logic          rx_hit_valid, tx_req_valid, tx_req_ide, tx_req_rtr, irq;
   logic          fifo_empty, fifo_head_ide, fifo_head_rtr, fifo_ovf;
   logic [SW-1:0] rx_hit_slot, tx_req_slot;
   logic [IW-1:0] tx_req_id, fifo_head_id;
   logic [N-1:0]  done;

   msgslot_hub dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_mode(cfg_mode),
      .cfg_id(cfg_id), .cfg_id_mask(cfg_id_mask), .cfg_ide(cfg_ide), .cfg_ide_mask(cfg_ide_mask),
      .cfg_rtr(cfg_rtr), .cfg_rtr_mask(cfg_rtr_mask), .cfg_auto(cfg_auto), .fifo_mode(fifo_mode),
      .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
      .rx_hit_valid(rx_hit_valid), .rx_hit_slot(rx_hit_slot),
      .tx_req_valid(tx_req_valid), .tx_req_slot(tx_req_slot), .tx_req_id(tx_req_id),
      .tx_req_ide(tx_req_ide), .tx_req_rtr(tx_req_rtr), .tx_done(tx_done),
      .done(done), .done_clr(done_clr), .irq_en(irq_en), .irq(irq),
      .fifo_pop(fifo_pop), .fifo_empty(fifo_empty), .fifo_head_id(fifo_head_id),
      .fifo_head_ide(fifo_head_ide), .fifo_head_rtr(fifo_head_rtr),
      .fifo_ovf(fifo_ovf), .fifo_ovf_clr(fifo_ovf_clr));

   int nchk = 0;
   int nfail = 0;
   localparam logic [IW-1:0] ALL = '1;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cfg_we = 0; cfg_slot = '0; cfg_mode = '0; cfg_id = '0; cfg_id_mask = '0;
      cfg_ide = 0; cfg_ide_mask = 0; cfg_rtr = 0; cfg_rtr_mask = 0; cfg_auto = 0;
      fifo_mode = 0; rx_valid = 0; rx_id = '0; rx_ide = 0; rx_rtr = 0; tx_done = 0;
      fifo_pop = 0; fifo_ovf_clr = 0; done_clr = '0; irq_en = '0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic cfg(int s, logic [1:0] m, logic [IW-1:0] id, logic [IW-1:0] idm,
                      logic ide, logic idem, logic rtr, logic rtrm, logic au);
      cfg_we = 1; cfg_slot = SW'(s); cfg_mode = m; cfg_id = id; cfg_id_mask = idm;
      cfg_ide = ide; cfg_ide_mask = idem; cfg_rtr = rtr; cfg_rtr_mask = rtrm; cfg_auto = au;
      tick();
      cfg_we = 0;
   endtask

   task automatic send(logic [IW-1:0] id, logic ide, logic rtr);
      rx_valid = 1; rx_id = id; rx_ide = ide; rx_rtr = rtr;
      tick();
      rx_valid = 0;
   endtask

   task automatic sent();
      tx_done = 1; tick(); tx_done = 0;
   endtask

   task automatic pop();
      fifo_pop = 1; tick(); fifo_pop = 0;
   endtask

   task automatic clr(logic [N-1:0] m);
      done_clr = m; tick(); done_clr = '0;
   endtask

   logic [N-1:0] pats [4] = '{16'hFFFF, 16'h8001, 16'h0F00, 16'h5A5A};

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 done", done, 0);
      chk("R1 irq", irq, 0);
      chk("R1 tx_req_valid", tx_req_valid, 0);
      chk("R1 fifo_empty", fifo_empty, 1);
      chk("R1 fifo_ovf", fifo_ovf, 0);

      // R2/R3 transmit order sweep
      foreach (pats[p]) begin
         logic [N-1:0] rem;
         do_reset();
         rem = pats[p];
         for (int k = 0; k < N; k++)
            if (rem[k]) cfg(k, 2'd1, IW'(k * 7 + 3), '0, k[0], 0, k[1], 0, 0);
         while (rem != '0) begin
            int lo = 0;
            for (int k = N - 1; k >= 0; k--) if (rem[k]) lo = k;
            chk("R2 tx_req_valid", tx_req_valid, 1);
            chk("R2 tx_req_slot", tx_req_slot, lo);
            chk("R2 tx_req_id", tx_req_id, lo * 7 + 3);
            chk("R2 tx_req_rtr", tx_req_rtr, (lo >> 1) & 1);
            sent();
            chk("R3 done bit", done[lo], 1);
            rem[lo] = 1'b0;
         end
         chk("R2 idle after all sent", tx_req_valid, 0);
         chk("R3 done pattern", done, pats[p]);
      end

      // R5/R6/R7 receive order sweep with all slots accepting anything
      do_reset();
      for (int k = 0; k < N; k++) cfg(k, 2'd2, '0, ALL, 0, 1, 0, 1, 0);
      for (int j = 0; j < N; j++) begin
         send(IW'(j * 11), j[0], j[1]);
         chk("R5 hit valid", rx_hit_valid, 1);
         chk("R5 hit slot", rx_hit_slot, N - 1 - j);
      end
      send(IW'(5), 0, 0);
      chk("R6 no slot left", rx_hit_valid, 0);
      chk("R6 done unchanged", done, 16'hFFFF);
      irq_en = 16'h0F0F; tick();
      chk("R7 irq set", irq, 1);
      clr(16'h0F0F);
      chk("R7 w1c", done, 16'hF0F0);
      chk("R7 irq masked", irq, 0);
      clr(16'hF000);
      chk("R7 w1c second", done, 16'h00F0);

      // R4 identifier mask sweep, one exact bit at a time
      do_reset();
      for (int b = 0; b < IW; b++) begin
         logic [IW-1:0] one;
         one = IW'(1) << b;
         cfg(5, 2'd2, '0, ~one, 0, 1, 0, 1, 0);
         send(one, 0, 0);
         chk("R4 exact bit rejects", rx_hit_valid, 0);
         send(~one, 1, 1);
         chk("R4 masked bits accept", rx_hit_valid, 1);
      end
      // R4 IDE and RTR
      cfg(5, 2'd2, IW'(29'h123), '0, 1, 0, 0, 0, 0);
      send(IW'(29'h123), 0, 0);
      chk("R4 ide exact", rx_hit_valid, 0);
      send(IW'(29'h123), 1, 1);
      chk("R4 rtr exact", rx_hit_valid, 0);
      send(IW'(29'h123), 1, 0);
      chk("R4 full match", rx_hit_slot, 5);
      // R12 retired slot ignores frames, rewrite re-arms
      send(IW'(29'h123), 1, 0);
      chk("R12 retired", rx_hit_valid, 0);
      cfg(5, 2'd2, IW'(29'h123), '0, 1, 0, 0, 1, 0);
      send(IW'(29'h123), 1, 1);
      chk("R12 rearmed rtr masked", rx_hit_valid, 1);

      // R8/R9 header queue
      do_reset();
      fifo_mode = 1;
      cfg(12, 2'd2, IW'(29'h50), IW'(29'h0F), 0, 1, 0, 1, 0);
      cfg(14, 2'd2, '0, ALL, 0, 1, 0, 1, 0);
      cfg(7, 2'd2, '0, ALL, 0, 1, 0, 1, 0);
      for (int j = 1; j <= 4; j++) begin
         send(IW'(29'h50 + j), 0, 0);
         chk("R8 queue hit", rx_hit_valid, 1);
         chk("R8 queue slot", rx_hit_slot, 12);
      end
      chk("R8 done on base", done, 16'h1000);
      chk("R8 not empty", fifo_empty, 0);
      send(IW'(29'h55), 0, 0);
      chk("R9 full drop", rx_hit_valid, 0);
      chk("R9 ovf", fifo_ovf, 1);
      chk("R9 lower slot untouched", done[7], 0);
      send(IW'(29'h99), 0, 0);
      chk("R8 top slots merged", rx_hit_slot, 7);
      for (int j = 1; j <= 4; j++) begin
         chk("R8 head order", fifo_head_id, 29'h50 + j);
         pop();
      end
      chk("R8 drained", fifo_empty, 1);
      chk("R9 ovf sticky", fifo_ovf, 1);
      fifo_ovf_clr = 1; tick(); fifo_ovf_clr = 0;
      chk("R9 ovf cleared", fifo_ovf, 0);

      // R10 auto-reply transmit
      do_reset();
      cfg(4, 2'd1, IW'(29'h77), '0, 0, 0, 0, 0, 1);
      chk("R10 waits", tx_req_valid, 0);
      send(IW'(29'h76), 0, 1);
      chk("R10 wrong id", tx_req_valid, 0);
      send(IW'(29'h77), 0, 0);
      chk("R10 data frame no trigger", tx_req_valid, 0);
      send(IW'(29'h77), 0, 1);
      chk("R10 triggered", tx_req_valid, 1);
      chk("R10 slot", tx_req_slot, 4);
      chk("R10 reply is data", tx_req_rtr, 0);
      sent();
      chk("R10 done", done, 16'h0010);

      // R11 auto-reply receive
      do_reset();
      cfg(10, 2'd2, IW'(29'h10), '0, 0, 0, 0, 0, 1);
      cfg(0, 2'd1, IW'(29'h10), '0, 0, 0, 1, 0, 0);
      send(IW'(29'h10), 0, 0);
      chk("R11 not primed", rx_hit_valid, 0);
      sent();
      chk("R11 remote sent", done, 16'h0001);
      send(IW'(29'h10), 0, 0);
      chk("R11 accepts answer", rx_hit_valid, 1);
      chk("R11 slot", rx_hit_slot, 10);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule